// File: doc/BRIEF.md
# Serial EEPROM Boot Image Loader

This block copies a program image out of an external serial EEPROM into local RAM as soon as reset is released. It is the bus controller on a two-wire I2C bus. It drives the clock and data lines through open-drain output enables. It reads the data line back through a separate input. No software set-up is needed and there is no start input: leaving reset starts the load.

The loader sets the memory's internal pointer once and then reads the whole image in a single pass. First it writes the device select byte and a two-byte start address. It then issues a repeated START and a device select for reading. After that it streams bytes, relying on the memory to advance its own pointer after every byte. Each byte goes to a RAM write port at consecutive addresses from zero. The loader acknowledges every byte except the final one, which it refuses, and then releases the bus with a STOP. A done flag reports a complete image. An error flag reports that the memory refused one of the four command bytes.

The bus timing comes from a divided system clock. `HALF_CLKS` system clocks make one SCL half period. The image length, the device address and the start address are all parameters. Only the low `ADDR_BITS` bits of the start address are sent; the unused upper bits go out as zero.

Top module: `eeprom_boot_loader`

## Requirements
- R1: While reset is high, both bus enables are low (lines released), and `ram_we`, `done` and `error` are all low.
- R2: After reset the loader sends a START and then the select byte `{DEV_ADDR, 0}`. It follows with the start address as two bytes, high byte first, with bits at and above `ADDR_BITS` sent as 0. Every byte goes out MSB first, and the ninth clock samples the acknowledge (0 means accepted).
- R3: The loader then sends a repeated START and the select byte `{DEV_ADDR, 1}`. A successful load contains exactly two START conditions and one STOP.
- R4: Data bytes are read MSB first. The loader drives ACK (SDA low) in the ninth clock after every data byte except the last, and leaves SDA released (NACK) after the last one. A STOP follows.
- R5: Each data byte produces a one-cycle `ram_we` pulse. `ram_addr` counts from 0 to `IMG_BYTES-1` with no gaps. `ram_wdata` holds the byte exactly as read, so there are exactly `IMG_BYTES` writes.
- R6: `done` rises in the cycle after the write to address `IMG_BYTES-1` and stays high until reset, and `error` stays low.
- R7: If any of the four command bytes (select for write, address high, address low, select for read) is refused, the loader sends no further byte. It ends with a STOP, raises `error` and holds it until reset, and makes no RAM write. `done` stays low.
- R8: SDA changes only while SCL is low, except in START and STOP. This is seen on the bus as exactly the START and STOP conditions listed in R3.
- R9: Every SCL high phase that ends in a falling edge lasts exactly `HALF_CLKS` system clocks. Every SCL low phase lasts at least `HALF_CLKS` system clocks.
- R10: A reset in the middle of a load drops the partial transfer. After reset falls, the complete sequence runs again from START, and RAM is rewritten from address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; its release starts a load |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| sda_in | input | 1 | Level sensed on the SDA line |
| ram_we | output | 1 | RAM write strobe, one cycle per image byte |
| ram_addr | output | AW = clog2(IMG_BYTES) | RAM byte address |
| ram_wdata | output | 8 | Byte to write |
| done | output | 1 | Image fully copied; held until reset |
| error | output | 1 | A command byte was refused; held until reset |

## Verification
The bench builds the loader with `IMG_BYTES` = 40 and `HALF_CLKS` = 4, so a complete load takes a few thousand cycles and can run several times in one simulation. It also sets `ADDR_BITS` = 15 with a start address of 0xFFE8. This shows that the unused top address bit is sent as zero. It also makes the bench's memory model wrap its 15-bit pointer past 0x7FFF partway through the image, while the RAM addresses must still run from 0 to 39 without a break. The memory model can refuse each of the four command bytes in turn. It also gets reset partway through a transfer.

// File: rtl/bootld_pkg.sv
package bootld_pkg;

  // Bus-level operations handled by the bit engine.
  typedef enum logic [1:0] {
    OP_START = 2'd0,  // START or repeated START
    OP_STOP  = 2'd1,
    OP_WRITE = 2'd2,  // 8 bits out, acknowledge in
    OP_READ  = 2'd3   // 8 bits in, acknowledge out
  } bus_op_e;

  // Steps of the load sequence.
  typedef enum logic [3:0] {
    SQ_OPEN   = 4'd0,
    SQ_SELW   = 4'd1,
    SQ_PTRHI  = 4'd2,
    SQ_PTRLO  = 4'd3,
    SQ_REOPEN = 4'd4,
    SQ_SELR   = 4'd5,
    SQ_STREAM = 4'd6,
    SQ_CLOSE  = 4'd7,
    SQ_HALT   = 4'd8
  } seq_step_e;

  function automatic logic [7:0] select_byte(input logic [6:0] dev, input logic rd);
    return {dev, rd};
  endfunction

endpackage

// File: rtl/bootld_qtimer.sv
// Quarter-bit pacing timer: emits a one-cycle tick every PERIOD clocks,
// counted from the last restart.
module bootld_qtimer #(
  parameter int PERIOD = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic tick
);
  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(PERIOD - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt  <= RELOAD;
      tick <= 1'b0;
    end else if (cnt == '0) begin
      cnt  <= RELOAD;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt - 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/bootld_bit_engine.sv
// Executes one bus operation at a time. Every operation is four quarter
// steps (START/STOP) or nine bits of four quarter steps (byte transfers).
module bootld_bit_engine
  import bootld_pkg::*;
#(
  parameter int HALF_CLKS = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_valid,
  input  bus_op_e    cmd_op,
  input  logic [7:0] cmd_byte,
  input  logic       cmd_nack,   // read: 1 releases SDA in the ninth clock
  output logic       op_done,
  output logic [7:0] rx_byte,
  output logic       rx_nack,    // write: sampled acknowledge level
  output logic       scl_oe,
  output logic       sda_oe,
  input  logic       sda_in
);
  localparam int QTR_CLKS = (HALF_CLKS / 2 > 0) ? HALF_CLKS / 2 : 1;
  localparam int BITS     = 9;
  localparam int BIT_W    = $clog2(BITS + 1);

  logic [1:0]       sda_sync;
  logic             tick;
  logic             busy;
  bus_op_e          op_q;
  logic [1:0]       step;
  logic [BIT_W-1:0] bit_idx;
  logic [7:0]       shreg;
  logic             nack_q;
  logic             is_byte;
  logic             accept;

  assign accept  = cmd_valid && !busy;
  assign is_byte = (op_q == OP_WRITE) || (op_q == OP_READ);
  assign rx_byte = shreg;

  always_ff @(posedge clk) begin
    if (rst) sda_sync <= 2'b11;
    else     sda_sync <= {sda_sync[0], sda_in};
  end

  bootld_qtimer #(.PERIOD(QTR_CLKS)) u_qtimer (
    .clk     (clk),
    .rst     (rst),
    .restart (accept),
    .tick    (tick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      op_q    <= OP_START;
      step    <= 2'd0;
      bit_idx <= '0;
      shreg   <= 8'h00;
      nack_q  <= 1'b0;
      rx_nack <= 1'b0;
      op_done <= 1'b0;
      scl_oe  <= 1'b0;
      sda_oe  <= 1'b0;
    end else begin
      op_done <= 1'b0;
      if (accept) begin
        busy    <= 1'b1;
        op_q    <= cmd_op;
        step    <= 2'd0;
        bit_idx <= '0;
        shreg   <= cmd_byte;
        nack_q  <= cmd_nack;
      end else if (busy && tick) begin
        step <= step + 2'd1;
        unique case (op_q)
          OP_START: begin
            unique case (step)
              2'd0: sda_oe <= 1'b0;   // SDA up while SCL low (or idle)
              2'd1: scl_oe <= 1'b0;   // SCL up
              2'd2: sda_oe <= 1'b1;   // SDA falls with SCL high: START
              default: begin
                scl_oe  <= 1'b1;      // SCL back low
                busy    <= 1'b0;
                op_done <= 1'b1;
              end
            endcase
          end
          OP_STOP: begin
            unique case (step)
              2'd0: sda_oe <= 1'b1;   // SDA low while SCL low
              2'd1: scl_oe <= 1'b0;   // SCL up
              2'd2: sda_oe <= 1'b0;   // SDA rises with SCL high: STOP
              default: begin
                busy    <= 1'b0;
                op_done <= 1'b1;
              end
            endcase
          end
          default: begin
            unique case (step)
              2'd0: begin
                if (bit_idx < BIT_W'(8))
                  sda_oe <= (op_q == OP_WRITE) ? !shreg[7] : 1'b0;
                else
                  sda_oe <= (op_q == OP_READ) ? !nack_q : 1'b0;
              end
              2'd1: scl_oe <= 1'b0;
              2'd2: ;
              default: begin
                scl_oe <= 1'b1;
                if (bit_idx < BIT_W'(8)) shreg <= {shreg[6:0], sda_sync[1]};
                else                     rx_nack <= sda_sync[1];
                if (bit_idx == BIT_W'(BITS - 1)) begin
                  busy    <= 1'b0;
                  op_done <= 1'b1;
                end else begin
                  bit_idx <= bit_idx + 1'b1;
                end
              end
            endcase
          end
        endcase
      end
    end
  end

  // R8: during a byte transfer SDA is held while SCL stays released.
  a_r8_sda_still_scl_high: assert property (@(posedge clk) disable iff (rst)
    (busy && is_byte && !scl_oe && !$past(scl_oe)) |-> $stable(sda_oe));

  // R2: the sequencer only hands over an operation when the engine is free.
  a_r2_cmd_only_when_free: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> !busy);

  // R9: between operations SCL is held low (STOP leaves the bus released).
  a_r9_scl_low_between_ops: assert property (@(posedge clk) disable iff (rst)
    (op_done && op_q != OP_STOP) |-> scl_oe);

endmodule

// File: rtl/bootld_sequencer.sv
// Load sequence: select/pointer write, repeated START, streaming read.
module bootld_sequencer
  import bootld_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR  = 7'h50,
  parameter logic [15:0] PTR_WORD = 16'h0000,
  parameter int         IMG_BYTES = 32768,
  parameter int         AW        = 15
) (
  input  logic          clk,
  input  logic          rst,
  output logic          cmd_valid,
  output bus_op_e       cmd_op,
  output logic [7:0]    cmd_byte,
  output logic          cmd_nack,
  input  logic          op_done,
  input  logic [7:0]    rx_byte,
  input  logic          rx_nack,
  output logic          ram_we,
  output logic [AW-1:0] ram_addr,
  output logic [7:0]    ram_wdata,
  output logic          done,
  output logic          error
);
  localparam logic [AW-1:0] LAST = AW'(IMG_BYTES - 1);

  seq_step_e     st;
  logic          issued;
  logic [AW-1:0] cnt;
  bus_op_e       nx_op;
  logic [7:0]    nx_byte;
  logic          nx_nack;

  always_comb begin
    nx_op   = OP_START;
    nx_byte = 8'h00;
    nx_nack = 1'b0;
    unique case (st)
      SQ_SELW:   begin nx_op = OP_WRITE; nx_byte = select_byte(DEV_ADDR, 1'b0); end
      SQ_PTRHI:  begin nx_op = OP_WRITE; nx_byte = PTR_WORD[15:8]; end
      SQ_PTRLO:  begin nx_op = OP_WRITE; nx_byte = PTR_WORD[7:0]; end
      SQ_SELR:   begin nx_op = OP_WRITE; nx_byte = select_byte(DEV_ADDR, 1'b1); end
      SQ_STREAM: begin nx_op = OP_READ;  nx_nack = (cnt == LAST); end
      SQ_CLOSE:  nx_op = OP_STOP;
      default:   nx_op = OP_START;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= SQ_OPEN;
      issued    <= 1'b0;
      cmd_valid <= 1'b0;
      cmd_op    <= OP_START;
      cmd_byte  <= 8'h00;
      cmd_nack  <= 1'b0;
      cnt       <= '0;
      ram_we    <= 1'b0;
      ram_addr  <= '0;
      ram_wdata <= 8'h00;
      done      <= 1'b0;
      error     <= 1'b0;
    end else begin
      cmd_valid <= 1'b0;
      ram_we    <= 1'b0;
      if (ram_we && ram_addr == LAST) done <= 1'b1;
      if (st != SQ_HALT) begin
        if (!issued) begin
          issued    <= 1'b1;
          cmd_valid <= 1'b1;
          cmd_op    <= nx_op;
          cmd_byte  <= nx_byte;
          cmd_nack  <= nx_nack;
        end else if (op_done) begin
          issued <= 1'b0;
          unique case (st)
            SQ_OPEN:   st <= SQ_SELW;
            SQ_REOPEN: st <= SQ_SELR;
            SQ_SELW, SQ_PTRHI, SQ_PTRLO, SQ_SELR: begin
              if (rx_nack) begin
                error <= 1'b1;
                st    <= SQ_CLOSE;
              end else begin
                unique case (st)
                  SQ_SELW:  st <= SQ_PTRHI;
                  SQ_PTRHI: st <= SQ_PTRLO;
                  SQ_PTRLO: st <= SQ_REOPEN;
                  default:  st <= SQ_STREAM;
                endcase
              end
            end
            SQ_STREAM: begin
              ram_we    <= 1'b1;
              ram_addr  <= cnt;
              ram_wdata <= rx_byte;
              if (cnt == LAST) st <= SQ_CLOSE;
              else             cnt <= cnt + 1'b1;
            end
            SQ_CLOSE: st <= SQ_HALT;
            default:  st <= SQ_HALT;
          endcase
        end
      end
    end
  end

  // R6: done never falls before reset.
  a_r6_done_sticky: assert property (@(posedge clk) disable iff (rst)
    $past(done) |-> done);

  // R6: done rises right after the write to the final address.
  a_r6_done_after_last_write: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> ($past(ram_we) && $past(ram_addr) == LAST));

  // R7: a failed load never also reports done, and error is held.
  a_r7_error_excludes_done: assert property (@(posedge clk) disable iff (rst)
    !(done && error));
  a_r7_error_sticky: assert property (@(posedge clk) disable iff (rst)
    $past(error) |-> error);

  // R5: no RAM write once the image is complete or a refusal was seen.
  a_r5_no_write_after_end: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> (!done && !error));

endmodule

// File: rtl/eeprom_boot_loader.sv
module eeprom_boot_loader
  import bootld_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR  = 7'h50,
  parameter int         BASE_ADDR = 0,
  parameter int         ADDR_BITS = 15,
  parameter int         IMG_BYTES = 32768,
  parameter int         HALF_CLKS = 250,
  localparam int        AW        = (IMG_BYTES > 1) ? $clog2(IMG_BYTES) : 1
) (
  input  logic          clk,
  input  logic          rst,
  output logic          scl_oe,
  output logic          sda_oe,
  input  logic          sda_in,
  output logic          ram_we,
  output logic [AW-1:0] ram_addr,
  output logic [7:0]    ram_wdata,
  output logic          done,
  output logic          error
);
  localparam logic [16:0] SPAN     = 17'(1) << ADDR_BITS;
  localparam logic [15:0] PTR_WORD = 16'(17'(BASE_ADDR) % SPAN);

  logic       cmd_valid;
  bus_op_e    cmd_op;
  logic [7:0] cmd_byte;
  logic       cmd_nack;
  logic       op_done;
  logic [7:0] rx_byte;
  logic       rx_nack;

  bootld_sequencer #(
    .DEV_ADDR  (DEV_ADDR),
    .PTR_WORD  (PTR_WORD),
    .IMG_BYTES (IMG_BYTES),
    .AW        (AW)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_byte  (cmd_byte),
    .cmd_nack  (cmd_nack),
    .op_done   (op_done),
    .rx_byte   (rx_byte),
    .rx_nack   (rx_nack),
    .ram_we    (ram_we),
    .ram_addr  (ram_addr),
    .ram_wdata (ram_wdata),
    .done      (done),
    .error     (error)
  );

  bootld_bit_engine #(.HALF_CLKS(HALF_CLKS)) u_eng (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_byte  (cmd_byte),
    .cmd_nack  (cmd_nack),
    .op_done   (op_done),
    .rx_byte   (rx_byte),
    .rx_nack   (rx_nack),
    .scl_oe    (scl_oe),
    .sda_oe    (sda_oe),
    .sda_in    (sda_in)
  );

  // R1: lines released and flags clear in the cycle after a reset edge.
  a_r1_reset_state: assert property (@(posedge clk)
    $past(rst) |-> (!scl_oe && !sda_oe && !ram_we && !done && !error));

endmodule

// File: tb/eeprom_boot_loader_tb.sv
module eeprom_boot_loader_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int IMG   = 40;
  localparam int HALF  = 4;
  localparam int BASE  = 'hFFE8;
  localparam int ABITS = 15;
  localparam int AWB   = $clog2(IMG);
  localparam int SENT  = BASE % (1 << ABITS);

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD / 2) clk = ~clk;

  wire            scl_oe, sda_oe, ram_we, done, error;
  wire [AWB-1:0]  ram_addr;
  wire [7:0]      ram_wdata;
  logic           mdl_pull = 1'b0;
  wire            scl = ~scl_oe;
  wire            sda = ~(sda_oe | mdl_pull);

  eeprom_boot_loader #(
    .DEV_ADDR(7'h50), .BASE_ADDR(BASE), .ADDR_BITS(ABITS),
    .IMG_BYTES(IMG), .HALF_CLKS(HALF)
  ) dut_i (
    .clk(clk), .rst(rst), .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .done(done), .error(error)
  );

  int total = 0;
  int bad = 0;
  logic [7:0] seed8 = 8'h3C;

  function automatic logic [7:0] rom(input logic [14:0] a);
    logic [15:0] t;
    t = {1'b0, a} * 16'd29;
    return t[7:0] ^ {1'b0, a[14:8]} ^ seed8;
  endfunction

  task automatic chk_eq(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_ge(input string req, input string what, input int act, input int lim);
    total++;
    if (act < lim) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected>=%0d", req, what, act, lim);
    end
  endtask

  // ---------------- memory model ----------------
  int   nack_sel = -1;  // 0..3 refuses that command byte, -1 none
  bit   in_txn = 0, skip = 0, rd_phase = 0, pend_rd = 0;
  int   mb = 0, byten = 0;
  logic [7:0]  sh = 8'h00, hi = 8'h00;
  logic [14:0] ptr = '0;
  logic mack = 1'b0;
  int   n_start = 0, n_stop = 0, n_wbytes = 0, n_macks = 0, n_mnacks = 0;
  int   got_cw = -1, got_hi = -1, got_lo = -1, got_cr = -1;

  always @(negedge sda) if (scl === 1'b1) begin
    n_start++; in_txn = 1; skip = 1; mb = 0; byten = 0;
    rd_phase = 0; pend_rd = 0; mdl_pull = 0;
  end

  always @(posedge sda) if (scl === 1'b1) begin
    n_stop++; in_txn = 0; rd_phase = 0; mdl_pull = 0;
  end

  always @(posedge scl) if (in_txn && !skip) begin
    if (mb < 8) sh = {sh[6:0], sda};
    else if (rd_phase) mack = sda;
  end

  always @(negedge scl) if (in_txn) begin
    if (skip) skip = 0;
    else begin
      logic [7:0] cur;
      bit ack;
      mb++;
      if (!rd_phase) begin
        if (mb == 8) begin
          n_wbytes++;
          ack = 1;
          case (byten)
            0: begin
              if (sh[0]) got_cr = sh; else got_cw = sh;
              ack = (sh[7:1] == 7'h50) && (nack_sel != (sh[0] ? 3 : 0));
              pend_rd = ack && sh[0];
            end
            1: begin got_hi = sh; hi = sh; ack = (nack_sel != 1); end
            2: begin got_lo = sh; ptr = {hi[6:0], sh}; ack = (nack_sel != 2); end
            default: ack = 1;
          endcase
          byten++;
          mdl_pull = ack;
        end else if (mb == 9) begin
          mb = 0;
          mdl_pull = 0;
          if (pend_rd) begin
            pend_rd = 0; rd_phase = 1;
            cur = rom(ptr); mdl_pull = ~cur[7];
          end
        end
      end else begin
        cur = rom(ptr);
        if (mb < 8) mdl_pull = ~cur[7-mb];
        else if (mb == 8) mdl_pull = 0;
        else begin
          mb = 0;
          if (!mack) begin
            n_macks++; ptr = ptr + 15'd1;
            cur = rom(ptr); mdl_pull = ~cur[7];
          end else begin
            n_mnacks++; rd_phase = 0; mdl_pull = 0;
          end
        end
      end
    end
  end

  // ---------------- monitors (sampled at falling clock) ----------------
  int n_writes = 0, bad_data = 0, exp_idx = 0, done_rise_ok = -1, done_drop = 0;
  bit done_prev = 0, we_last_prev = 0, scl_prev = 1, first_high = 1;
  int run = 0, hi_min = 1000000, hi_max = 0, lo_min = 1000000;

  always @(negedge clk) if (!rst) begin
    if (ram_we) begin
      logic [14:0] a;
      a = 15'(SENT + exp_idx);
      if (int'(ram_addr) != exp_idx || ram_wdata != rom(a)) begin
        bad_data++;
        $display("FAIL R5 write %0d: actual addr=%0d data=%0d expected addr=%0d data=%0d",
                 exp_idx, ram_addr, ram_wdata, exp_idx, rom(a));
      end
      n_writes++; exp_idx++;
    end
    if (done && !done_prev) done_rise_ok = we_last_prev ? 1 : 0;
    if (!done && done_prev) done_drop++;
    done_prev = done;
    we_last_prev = ram_we && (int'(ram_addr) == IMG - 1);
    if (scl == scl_prev) run++;
    else begin
      if (scl_prev) begin
        if (!first_high) begin
          if (run < hi_min) hi_min = run;
          if (run > hi_max) hi_max = run;
        end
        first_high = 0;
      end else if (run < lo_min) lo_min = run;
      run = 1;
    end
    scl_prev = scl;
  end

  // ---------------- watchdog ----------------
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected<%0d cycles", cyc, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic clear_all();
    in_txn = 0; skip = 0; rd_phase = 0; pend_rd = 0; mb = 0; byten = 0; mdl_pull = 0;
    n_start = 0; n_stop = 0; n_wbytes = 0; n_macks = 0; n_mnacks = 0;
    got_cw = -1; got_hi = -1; got_lo = -1; got_cr = -1;
    n_writes = 0; bad_data = 0; exp_idx = 0; done_rise_ok = -1; done_drop = 0;
    done_prev = 0; we_last_prev = 0; scl_prev = 1; first_high = 1; run = 0;
    hi_min = 1000000; hi_max = 0; lo_min = 1000000;
  endtask

  task automatic start_run(input int sel);
    rst = 1'b1;
    nack_sel = sel;
    seed8 = 8'($urandom);
    repeat (4) @(negedge clk);
    clear_all();
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic finish_good(input string tag);
    while (!done && !error) @(negedge clk);
    while (n_stop < 1) @(negedge clk);
    repeat (30) @(negedge clk);
    chk_eq("R2", {tag, " select write"}, got_cw, 'hA0);
    chk_eq("R2", {tag, " pointer high (top bit dropped)"}, got_hi, (SENT >> 8) & 'hFF);
    chk_eq("R2", {tag, " pointer low"}, got_lo, SENT & 'hFF);
    chk_eq("R3", {tag, " select read"}, got_cr, 'hA1);
    chk_eq("R3", {tag, " START count (R8)"}, n_start, 2);
    chk_eq("R3", {tag, " STOP count (R8)"}, n_stop, 1);
    chk_eq("R4", {tag, " bytes acknowledged"}, n_macks, IMG - 1);
    chk_eq("R4", {tag, " bytes refused"}, n_mnacks, 1);
    chk_eq("R5", {tag, " write count"}, n_writes, IMG);
    chk_eq("R5", {tag, " bad writes"}, bad_data, 0);
    chk_eq("R6", {tag, " done rise after last write"}, done_rise_ok, 1);
    chk_eq("R6", {tag, " done held"}, int'(done) + 2 * done_drop, 1);
    chk_eq("R6", {tag, " error low"}, int'(error), 0);
    chk_eq("R9", {tag, " shortest SCL high"}, hi_min, HALF);
    chk_eq("R9", {tag, " longest SCL high"}, hi_max, HALF);
    chk_ge("R9", {tag, " shortest SCL low"}, lo_min, HALF);
  endtask

  initial begin
    void'($urandom(32'h5EED));
    rst = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk_eq("R1", "scl_oe in reset", int'(scl_oe), 0);
    chk_eq("R1", "sda_oe in reset", int'(sda_oe), 0);
    chk_eq("R1", "ram_we in reset", int'(ram_we), 0);
    chk_eq("R1", "done in reset", int'(done), 0);
    chk_eq("R1", "error in reset", int'(error), 0);

    // Plain load
    start_run(-1);
    finish_good("load1");

    // R10: reset in mid-stream, then a full reload
    begin
      int stop_at;
      stop_at = 3 + int'($urandom % 20);
      start_run(-1);
      while (n_writes < stop_at) @(negedge clk);
      repeat (int'($urandom % 7)) @(negedge clk);
    end
    start_run(-1);
    chk_eq("R10", "no writes just after re-reset", n_writes, 0);
    finish_good("R10 reload");

    // R7: refusal of each command byte
    for (int s = 0; s < 4; s++) begin
      start_run(s);
      while (!error && !done) @(negedge clk);
      while (n_stop < 1) @(negedge clk);
      repeat (40) @(negedge clk);
      chk_eq("R7", $sformatf("sel%0d error", s), int'(error), 1);
      chk_eq("R7", $sformatf("sel%0d done", s), int'(done), 0);
      chk_eq("R7", $sformatf("sel%0d writes", s), n_writes, 0);
      chk_eq("R7", $sformatf("sel%0d command bytes sent", s), n_wbytes, s + 1);
      chk_eq("R7", $sformatf("sel%0d STOP count", s), n_stop, 1);
      chk_eq("R7", $sformatf("sel%0d START count", s), n_start, (s == 3) ? 2 : 1);
    end

    // Another plain load with fresh random content
    start_run(-1);
    finish_good("load3");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule